// File: doc/BRIEF.md
# Exception and Interrupt Control Unit

This unit sits beside a simple 32-bit processor pipeline and decides when normal instruction flow must be abandoned. The datapath raises four kinds of synchronous fault: arithmetic overflow, bad data address, undefined instruction and trap. External devices drive a set of level interrupt lines. When a fault or an enabled interrupt is taken, the unit asks the fetch stage to jump to one fixed kernel entry address, 0x80000180. It records the address of the affected instruction, a five-bit cause code and, for address faults, the offending address. It also raises an exception-level flag that keeps the processor in kernel mode and blocks nested interrupts.

Kernel software reads and writes the unit's registers through a register-number port: 8 holds the bad address, 12 the status, 13 the cause and 14 the return address. A return-from-exception pulse sends fetch back to the stored return address and clears the exception level. To skip a faulting instruction, software must first add four to the stored address.

Top module: `eic_ctrl`

## Requirements
- R1: After a synchronous active-high reset, registers 8, 12, 13 and 14 all read 0, `redirect_valid` is 0 and `kernel_mode` is 0.
- R2: In any cycle where a synchronous fault request is high, `redirect_valid` is 1 and `redirect_pc` is 0x80000180 in that same cycle. From the next cycle, register 14 holds that cycle's `instr_pc` and `kernel_mode` (status bit 1) is 1.
- R3: The cause code is stored in cause bits 6:2. The codes are: overflow 12 (cause reads 0x30 with nothing pending), bad address 4, undefined instruction 10 and trap 13. When several faults are requested together, the priority from highest to lowest is bad address, undefined instruction, overflow, trap.
- R4: A taken bad-address fault loads register 8 with `fault_addr`. No other event changes register 8.
- R5: A high level on hardware line i sets cause bit 8+i at the next clock, whatever the mask and enable bits hold. The bit stays set after the line drops, until software writes a 0 to it. A line that is high overrides a clearing write in the same cycle.
- R6: Cause bits 14 and 15 are software interrupt bits. Only a write to register 13 sets or clears them; the hardware lines never change them.
- R7: An interrupt is taken only when status bit 0 (global enable) is 1, status bit 1 (exception level) is 0, and some cause bit 8+k is set together with status bit 8+k. A taken interrupt redirects to 0x80000180, stores code 0 and `instr_pc`, and sets the exception level.
- R8: When a synchronous fault and a takeable interrupt occur in the same cycle, the fault is taken and its code is stored.
- R9: `eret` with no fault and no takeable interrupt redirects to the current register 14 value in the same cycle and clears the exception level at the next clock. A software write to register 14 takes effect before the return.
- R10: Writes update status bits 0, 1 and 15:8, the cause interrupt bits (per R5 and R6), and all 32 bits of register 14. Register 8 is read-only. A write in a cycle that takes a fault, takes an interrupt or has `eret` high is discarded. Register numbers that are not mapped read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| instr_pc | input | 32 | Address of the instruction at the exception point |
| exc_overflow | input | 1 | Arithmetic overflow request |
| exc_bad_addr | input | 1 | Bad data address request |
| exc_undef | input | 1 | Undefined instruction request |
| exc_trap | input | 1 | Trap request |
| fault_addr | input | 32 | Offending data address for a bad-address fault |
| irq_lines | input | 6 | Hardware interrupt lines, level sensitive |
| eret | input | 1 | Return-from-exception executes |
| reg_wr_en | input | 1 | Register write strobe |
| reg_wr_num | input | 5 | Register number to write |
| reg_wr_data | input | 32 | Write data |
| reg_rd_num | input | 5 | Register number to read |
| reg_rd_data | output | 32 | Read data (combinational) |
| redirect_valid | output | 1 | Fetch must jump this cycle |
| redirect_pc | output | 32 | Target address for the jump |
| kernel_mode | output | 1 | Exception level is set |

## Verification
A wrong code or priority choice shows up as a bad cause value on the very next read of register 13. A wrong stored return address appears one cycle later, as a wrong `redirect_pc` on the following `eret`. A pending bit that is lost or not latched stays hidden until the interrupt is unmasked, at which point it shows as a missing or spurious `redirect_valid` in the first enabled cycle. A stuck exception level appears at once on `kernel_mode`, and as interrupts that never get taken after a return.

// File: rtl/eic_pkg.sv
package eic_pkg;

    localparam int XLEN = 32;
    localparam logic [XLEN-1:0] KERNEL_ENTRY = 32'h8000_0180;

    localparam logic [4:0] RN_BADVADDR = 5'd8;
    localparam logic [4:0] RN_STATUS   = 5'd12;
    localparam logic [4:0] RN_CAUSE    = 5'd13;
    localparam logic [4:0] RN_EPC      = 5'd14;

    localparam int IRQ_FIELD_LSB = 8;

    typedef enum logic [4:0] {
        CODE_INT   = 5'd0,
        CODE_ADDR  = 5'd4,
        CODE_UNDEF = 5'd10,
        CODE_OVF   = 5'd12,
        CODE_TRAP  = 5'd13
    } exc_code_e;

    typedef struct packed {
        logic addr;
        logic undef;
        logic ovf;
        logic trap;
    } fault_req_t;

    function automatic logic any_fault(input fault_req_t r);
        return r.addr | r.undef | r.ovf | r.trap;
    endfunction

endpackage

// File: rtl/eic_arbiter.sv
module eic_arbiter
    import eic_pkg::*;
(
    input  fault_req_t req,
    input  logic       int_ok,
    output logic       take_fault,
    output logic       take_int,
    output exc_code_e  code
);
    always_comb begin
        take_fault = any_fault(req);
        take_int   = int_ok && !take_fault;
        if (req.addr)       code = CODE_ADDR;
        else if (req.undef) code = CODE_UNDEF;
        else if (req.ovf)   code = CODE_OVF;
        else if (req.trap)  code = CODE_TRAP;
        else                code = CODE_INT;
    end
endmodule

// File: rtl/eic_pending.sv
module eic_pending #(
    parameter int NUM_HW = 6,
    parameter int NUM_SW = 2,
    localparam int IRQ_W = NUM_HW + NUM_SW
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [NUM_HW-1:0] lines,
    input  logic              wr_en,
    input  logic [IRQ_W-1:0]  wr_bits,
    output logic [IRQ_W-1:0]  pend
);
    for (genvar i = 0; i < IRQ_W; i++) begin : g_bit
        if (i < NUM_HW) begin : g_hw
            always_ff @(posedge clk) begin
                if (rst)
                    pend[i] <= 1'b0;
                else
                    pend[i] <= (pend[i] & (wr_en ? wr_bits[i] : 1'b1)) | lines[i];
            end
        end else begin : g_sw
            always_ff @(posedge clk) begin
                if (rst)
                    pend[i] <= 1'b0;
                else if (wr_en)
                    pend[i] <= wr_bits[i];
            end
        end
    end
endmodule

// File: rtl/eic_ctrl.sv
module eic_ctrl
    import eic_pkg::*;
#(
    parameter int NUM_HW = 6,
    parameter int NUM_SW = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [XLEN-1:0]  instr_pc,
    input  logic             exc_overflow,
    input  logic             exc_bad_addr,
    input  logic             exc_undef,
    input  logic             exc_trap,
    input  logic [XLEN-1:0]  fault_addr,
    input  logic [NUM_HW-1:0] irq_lines,
    input  logic             eret,
    input  logic             reg_wr_en,
    input  logic [4:0]       reg_wr_num,
    input  logic [XLEN-1:0]  reg_wr_data,
    input  logic [4:0]       reg_rd_num,
    output logic [XLEN-1:0]  reg_rd_data,
    output logic             redirect_valid,
    output logic [XLEN-1:0]  redirect_pc,
    output logic             kernel_mode
);
    localparam int IRQ_W = NUM_HW + NUM_SW;

    fault_req_t       req;
    logic             st_ie, st_exl;
    logic [IRQ_W-1:0] st_im;
    logic [IRQ_W-1:0] pend;
    exc_code_e        code_q, code_sel;
    logic [XLEN-1:0]  epc_q, badva_q;
    logic             take_fault, take_int, int_ok, eret_fire, wr_ok;

    assign req       = '{addr: exc_bad_addr, undef: exc_undef, ovf: exc_overflow, trap: exc_trap};
    assign int_ok    = st_ie && !st_exl && (|(pend & st_im));
    assign eret_fire = eret && !take_fault && !take_int;
    assign wr_ok     = reg_wr_en && !take_fault && !take_int && !eret;

    eic_arbiter u_arb (
        .req       (req),
        .int_ok    (int_ok),
        .take_fault(take_fault),
        .take_int  (take_int),
        .code      (code_sel)
    );

    eic_pending #(.NUM_HW(NUM_HW), .NUM_SW(NUM_SW)) u_pend (
        .clk    (clk),
        .rst    (rst),
        .lines  (irq_lines),
        .wr_en  (wr_ok && reg_wr_num == RN_CAUSE),
        .wr_bits(reg_wr_data[IRQ_FIELD_LSB +: IRQ_W]),
        .pend   (pend)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st_ie   <= 1'b0;
            st_exl  <= 1'b0;
            st_im   <= '0;
            code_q  <= CODE_INT;
            epc_q   <= '0;
            badva_q <= '0;
        end else if (take_fault || take_int) begin
            st_exl <= 1'b1;
            code_q <= code_sel;
            epc_q  <= instr_pc;
            if (take_fault && req.addr)
                badva_q <= fault_addr;
        end else if (eret_fire) begin
            st_exl <= 1'b0;
        end else if (wr_ok) begin
            if (reg_wr_num == RN_STATUS) begin
                st_ie  <= reg_wr_data[0];
                st_exl <= reg_wr_data[1];
                st_im  <= reg_wr_data[IRQ_FIELD_LSB +: IRQ_W];
            end
            if (reg_wr_num == RN_EPC)
                epc_q <= reg_wr_data;
        end
    end

    always_comb begin
        reg_rd_data = '0;
        unique case (reg_rd_num)
            RN_BADVADDR: reg_rd_data = badva_q;
            RN_EPC:      reg_rd_data = epc_q;
            RN_STATUS: begin
                reg_rd_data[0] = st_ie;
                reg_rd_data[1] = st_exl;
                reg_rd_data[IRQ_FIELD_LSB +: IRQ_W] = st_im;
            end
            RN_CAUSE: begin
                reg_rd_data[6:2] = code_q;
                reg_rd_data[IRQ_FIELD_LSB +: IRQ_W] = pend;
            end
            default: reg_rd_data = '0;
        endcase
    end

    assign redirect_valid = take_fault || take_int || eret_fire;
    assign redirect_pc    = eret_fire ? epc_q : KERNEL_ENTRY;
    assign kernel_mode    = st_exl;

endmodule

// File: rtl/eic_ctrl_chk.sv
module eic_ctrl_chk #(
    parameter int NUM_HW = 6,
    parameter int IRQ_W  = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              exc_overflow,
    input logic              exc_bad_addr,
    input logic              exc_undef,
    input logic              exc_trap,
    input logic [31:0]       fault_addr,
    input logic [NUM_HW-1:0] irq_lines,
    input logic              eret,
    input logic              redirect_valid,
    input logic [31:0]       redirect_pc,
    input logic              kernel_mode,
    input logic              ie,
    input logic [IRQ_W-1:0]  pend,
    input logic [31:0]       badva
);
    logic any_req;
    assign any_req = exc_overflow | exc_bad_addr | exc_undef | exc_trap;

    assert_entry_R2: assert property (@(posedge clk) disable iff (rst)
        any_req |-> (redirect_valid && redirect_pc == 32'h8000_0180));

    assert_level_R2: assert property (@(posedge clk) disable iff (rst)
        any_req |=> kernel_mode);

    assert_badva_R4: assert property (@(posedge clk) disable iff (rst)
        exc_bad_addr |=> (badva == $past(fault_addr)));

    assert_latch_R5: assert property (@(posedge clk) disable iff (rst)
        (|irq_lines) |=> ((pend[NUM_HW-1:0] & $past(irq_lines)) == $past(irq_lines)));

    assert_mask_R7: assert property (@(posedge clk) disable iff (rst)
        (!ie && !any_req && !eret) |-> !redirect_valid);

    assert_return_R9: assert property (@(posedge clk) disable iff (rst)
        (eret && !any_req && kernel_mode) |=> !kernel_mode);

endmodule

bind eic_ctrl eic_ctrl_chk #(.NUM_HW(NUM_HW), .IRQ_W(NUM_HW + NUM_SW)) u_chk (
    .clk           (clk),
    .rst           (rst),
    .exc_overflow  (exc_overflow),
    .exc_bad_addr  (exc_bad_addr),
    .exc_undef     (exc_undef),
    .exc_trap      (exc_trap),
    .fault_addr    (fault_addr),
    .irq_lines     (irq_lines),
    .eret          (eret),
    .redirect_valid(redirect_valid),
    .redirect_pc   (redirect_pc),
    .kernel_mode   (kernel_mode),
    .ie            (st_ie),
    .pend          (pend),
    .badva         (badva_q)
);

// File: tb/sim_eic_ctrl.sv
`timescale 1ns/100ps
module sim_eic_ctrl;
    logic        clk = 1'b0;
    always #2.5 clk = ~clk;

    logic        rst = 1'b1;
    logic [31:0] instr_pc = '0, fault_addr = '0, reg_wr_data = '0;
    logic        exc_overflow = 0, exc_bad_addr = 0, exc_undef = 0, exc_trap = 0;
    logic [5:0]  irq_lines = '0;
    logic        eret = 0, reg_wr_en = 0;
    logic [4:0]  reg_wr_num = '0, reg_rd_num = '0;
    logic [31:0] reg_rd_data, redirect_pc;
    logic        redirect_valid, kernel_mode;

    eic_ctrl u0 (
        .clk(clk), .rst(rst), .instr_pc(instr_pc),
        .exc_overflow(exc_overflow), .exc_bad_addr(exc_bad_addr),
        .exc_undef(exc_undef), .exc_trap(exc_trap), .fault_addr(fault_addr),
        .irq_lines(irq_lines), .eret(eret), .reg_wr_en(reg_wr_en),
        .reg_wr_num(reg_wr_num), .reg_wr_data(reg_wr_data),
        .reg_rd_num(reg_rd_num), .reg_rd_data(reg_rd_data),
        .redirect_valid(redirect_valid), .redirect_pc(redirect_pc),
        .kernel_mode(kernel_mode)
    );

    int    n_chk = 0, n_fail = 0;
    bit    done = 0;
    string tag = "R1";

    // behavioural reference state
    bit          m_ie, m_exl;
    bit [7:0]    m_im, m_pend;
    int          m_code;
    bit [31:0]   m_epc, m_bad;

    task automatic chk(string t, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", t, act, exp);
        end
    endtask

    function automatic bit [31:0] m_read(int num);
        case (num)
            8:  return m_bad;
            12: return {16'h0, m_im, 6'h0, m_exl, m_ie};
            13: return {16'h0, m_pend, 1'b0, m_code[4:0], 2'b00};
            14: return m_epc;
            default: return 32'h0;
        endcase
    endfunction

    // compare against the model, then advance one clock
    task automatic step();
        bit any, intok, rv, wr, wc;
        int c;
        bit [31:0] rp;
        #0.4;
        any   = exc_overflow | exc_bad_addr | exc_undef | exc_trap;
        intok = m_ie && !m_exl && ((m_pend & m_im) != 0);
        rv    = !rst && (any || intok || eret);
        rp    = (any || intok) ? 32'h8000_0180 : m_epc;
        chk({tag, " redirect_valid"}, {31'h0, redirect_valid}, {31'h0, rv});
        if (rv) chk({tag, " redirect_pc"}, redirect_pc, rp);
        chk({tag, " kernel_mode"}, {31'h0, kernel_mode}, {31'h0, m_exl});
        chk({tag, " read data"}, reg_rd_data, m_read(int'(reg_rd_num)));
        c = exc_bad_addr ? 4 : exc_undef ? 10 : exc_overflow ? 12 : exc_trap ? 13 : 0;
        wr = reg_wr_en && !any && !intok && !eret;
        wc = wr && reg_wr_num == 13;
        @(posedge clk);
        if (rst) begin
            m_ie = 0; m_exl = 0; m_im = 0; m_pend = 0; m_code = 0; m_epc = 0; m_bad = 0;
        end else begin
            for (int k = 0; k < 8; k++) begin
                if (k < 6) m_pend[k] = (wc ? (m_pend[k] & reg_wr_data[8+k]) : m_pend[k]) | irq_lines[k];
                else if (wc) m_pend[k] = reg_wr_data[8+k];
            end
            if (any || intok) begin
                m_exl = 1; m_code = c; m_epc = instr_pc;
                if (exc_bad_addr) m_bad = fault_addr;
            end else if (eret) begin
                m_exl = 0;
            end else if (wr) begin
                if (reg_wr_num == 12) begin
                    m_ie = reg_wr_data[0]; m_exl = reg_wr_data[1]; m_im = reg_wr_data[15:8];
                end
                if (reg_wr_num == 14) m_epc = reg_wr_data;
            end
        end
        @(negedge clk);
        exc_overflow = 0; exc_bad_addr = 0; exc_undef = 0; exc_trap = 0;
        eret = 0; reg_wr_en = 0;
    endtask

    task automatic rd_expect(logic [4:0] num, logic [31:0] exp, string t);
        reg_rd_num = num;
        #0.4;
        chk(t, reg_rd_data, exp);
    endtask

    task automatic wr(logic [4:0] num, logic [31:0] d);
        reg_wr_en = 1; reg_wr_num = num; reg_wr_data = d;
        step();
    endtask

    task automatic do_eret();
        eret = 1;
        step();
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_fail++; n_chk++;
            $display("FAIL watchdog: actual hung expected finished");
            summary();
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        step(); step();
        rst = 0;
        step();
        // R1 reset state
        tag = "R1";
        rd_expect(8, 0, "R1 badvaddr");
        rd_expect(12, 0, "R1 status");
        rd_expect(13, 0, "R1 cause");
        rd_expect(14, 0, "R1 epc");
        chk("R1 kernel_mode", {31'h0, kernel_mode}, 0);

        // R2/R3 overflow
        tag = "R3";
        instr_pc = 32'h0040_0008; exc_overflow = 1;
        #0.4;
        chk("R2 entry redirect", redirect_pc, 32'h8000_0180);
        step();
        rd_expect(13, 32'h30, "R3 overflow cause");
        rd_expect(14, 32'h0040_0008, "R2 epc");
        chk("R2 kernel_mode", {31'h0, kernel_mode}, 1);

        // R9 skip and return
        tag = "R9";
        wr(14, 32'h0040_000c);
        eret = 1;
        #0.4;
        chk("R9 return target", redirect_pc, 32'h0040_000c);
        step();
        chk("R9 level cleared", {31'h0, kernel_mode}, 0);

        // R4 bad address with undefined at once
        tag = "R4";
        instr_pc = 32'h0040_0020; fault_addr = 32'h1001_0003;
        exc_bad_addr = 1; exc_undef = 1;
        step();
        rd_expect(13, 32'h10, "R3 bad address code priority");
        rd_expect(8, 32'h1001_0003, "R4 badvaddr loaded");
        do_eret();

        // R3 priority and codes, R4 untouched
        tag = "R3";
        fault_addr = 32'hdead_beef;
        exc_undef = 1; exc_overflow = 1; exc_trap = 1;
        step();
        rd_expect(13, 32'h28, "R3 undefined over overflow");
        rd_expect(8, 32'h1001_0003, "R4 badvaddr kept");
        do_eret();
        exc_trap = 1;
        step();
        rd_expect(13, 32'h34, "R3 trap code");
        do_eret();

        // R5 hardware pending latch while disabled
        tag = "R5";
        irq_lines = 6'b000001; step();
        irq_lines = 6'b000000; step();
        rd_expect(13, 32'h134, "R5 pending latched");
        step();
        rd_expect(13, 32'h134, "R5 pending held");
        irq_lines = 6'b000001; wr(13, 32'h0);
        irq_lines = 6'b000000;
        rd_expect(13, 32'h134, "R5 line beats clear");
        wr(13, 32'h0);
        rd_expect(13, 32'h34, "R5 cleared by write");

        // R6 software bits
        tag = "R6";
        wr(13, 32'h8000);
        rd_expect(13, 32'h8034, "R6 software bit set");
        irq_lines = 6'b111111; step();
        irq_lines = 6'b000000; step();
        rd_expect(13, 32'hbf34, "R6 lines leave software bits");
        wr(13, 32'h0);
        rd_expect(13, 32'h34, "R6 cleared");

        // R7 masking and enable
        tag = "R7";
        wr(13, 32'h4000);
        wr(12, 32'h1);
        #0.4;
        chk("R7 masked no redirect", {31'h0, redirect_valid}, 0);
        step();
        wr(12, 32'h4001);
        instr_pc = 32'h0040_0100;
        #0.4;
        chk("R7 interrupt taken", {31'h0, redirect_valid}, 1);
        step();
        rd_expect(13, 32'h4000, "R7 interrupt code zero");
        rd_expect(14, 32'h0040_0100, "R7 epc");
        #0.4;
        chk("R7 blocked at level", {31'h0, redirect_valid}, 0);
        step();
        wr(13, 32'h0);
        do_eret();

        // R8 fault beats interrupt
        tag = "R8";
        wr(12, 32'h0201);
        irq_lines = 6'b000010; step();
        irq_lines = 6'b000000;
        instr_pc = 32'h0040_0200; exc_overflow = 1;
        step();
        rd_expect(13, 32'h230, "R8 fault code wins");
        do_eret();
        step();
        wr(13, 32'h0);
        do_eret();
        wr(12, 32'h0);

        // R10 write rules
        tag = "R10";
        instr_pc = 32'h0040_0300; exc_trap = 1;
        reg_wr_en = 1; reg_wr_num = 14; reg_wr_data = 32'h1234_5678;
        step();
        rd_expect(14, 32'h0040_0300, "R10 write discarded on fault");
        do_eret();
        wr(8, 32'h0);
        rd_expect(8, 32'h1001_0003, "R10 badvaddr read-only");
        rd_expect(3, 32'h0, "R10 unmapped reads zero");
        wr(12, 32'hffff_ff03);
        rd_expect(12, 32'h0000_ff03, "R10 status fields");
        wr(12, 32'h0);
        step();

        done = 1;
        summary();
        $finish;
    end
endmodule